// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block manages the power state of a dual data converter from two control inputs: a sleep request that forces the deepest low-power state, and a run request that chooses between full operation and a light low-power state. It produces one of three operating modes (active, standby, shutdown) plus a transient wake mode. It drives separate enables for the voltage reference, the current-control amplifier and the output current array. The analog parts appear here only as those enable bits.

Leaving a low-power mode is timed. A counter, loaded with a parameterised cycle count, holds the ready flag low while the analog circuitry settles. The count is long after shutdown and short after standby. A low-power request that arrives during the count cancels it at once. The block also owns the output code seen by the converter. While active it tracks the input code. In a low-power mode it either parks the code at zero or raises an output-disable flag, chosen by a parameter. On the way back to active it presents the code held before sleep.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset puts the block in shutdown (mode code 2'b10) with ready, ref_en, amp_en and arr_en low and data_out zero.
- R2: While the synchronised sleep_req is 1, the block goes to shutdown whatever run_req is, and ref_en, amp_en and arr_en are all 0.
- R3: With sleep_req 0 and run_req 0 the block goes to standby (mode code 2'b01) with ref_en and amp_en 1, arr_en 0 and ready 0.
- R4: With sleep_req 0 and run_req 1 seen in shutdown, the block spends exactly WAKE_SHDN_CYC cycles in wake (mode code 2'b11) and then enters active (mode code 2'b00).
- R5: With sleep_req 0 and run_req 1 seen in standby, the block spends exactly WAKE_STBY_CYC cycles in wake and then enters active.
- R6: During wake, ref_en, amp_en and arr_en are all 1 and ready is 0.
- R7: A shutdown or standby request seen during wake ends the count, and the block goes directly to the requested mode on the next cycle without passing through active.
- R8: Each control input passes through two flip-flops, so the mode register first reflects an input change on the third rising clock edge after that change.
- R9: With PARK_ZERO=1, data_out is 0 and out_dis is 0 in standby and shutdown.
- R10: With PARK_ZERO=0, out_dis is 1 in standby and shutdown, and data_out keeps the last captured code.
- R11: In active, data_in is captured on every rising edge and appears on data_out after it. During wake and on the first active cycle, data_out shows the code captured before the low-power mode.
- R12: ready is 1 exactly when the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Asynchronous shutdown request, overrides run_req |
| run_req | input | 1 | Asynchronous run request (1 = active, 0 = standby) |
| data_in | input | DW | Converter code from upstream |
| mode | output | 2 | Current mode: 00 active, 01 standby, 10 shutdown, 11 wake |
| ready | output | 1 | Outputs settled and valid |
| ref_en | output | 1 | Reference enable |
| amp_en | output | 1 | Control amplifier enable |
| arr_en | output | 1 | Output current array enable |
| data_out | output | DW | Code presented to the converter |
| out_dis | output | 1 | Output disable flag (used when PARK_ZERO=0) |

## Verification
The hardest case to reach from the ports is a low-power request that lands during a wake count, before the count expires. The change has to clear the two-stage synchroniser while the counter is still running. The stimulus starts a short standby wake and raises sleep_req two cycles into the wake window. It also starts a long shutdown wake and drops run_req early. The checks confirm that the mode falls straight into the requested low-power state and that ready never rises.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_STBY   = 2'b01,
    PM_SHDN   = 2'b10,
    PM_WAKE   = 2'b11
  } pm_mode_e;

  function automatic logic pm_is_low(input pm_mode_e m);
    return (m == PM_STBY) || (m == PM_SHDN);
  endfunction
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val - CW'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pmc_hold.sv
module pmc_hold #(
  parameter int unsigned DW = 8,
  parameter bit PARK_ZERO = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          park,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dis
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)
      hold_q <= '0;
    else if (capture)
      hold_q <= din;
  end

  generate
    if (PARK_ZERO) begin : g_park_zero
      assign dout = park ? '0 : hold_q;
      assign dis  = 1'b0;
    end else begin : g_park_dis
      assign dout = hold_q;
      assign dis  = park;
    end
  endgenerate
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int unsigned DW            = 8,
  parameter int unsigned WAKE_SHDN_CYC = 2000,
  parameter int unsigned WAKE_STBY_CYC = 20,
  parameter bit          PARK_ZERO     = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          run_req,
  input  logic [DW-1:0] data_in,
  output logic [1:0]    mode,
  output logic          ready,
  output logic          ref_en,
  output logic          amp_en,
  output logic          arr_en,
  output logic [DW-1:0] data_out,
  output logic          out_dis
);
  import pmc_pkg::*;

  localparam int unsigned MAX_CYC = (WAKE_SHDN_CYC > WAKE_STBY_CYC) ? WAKE_SHDN_CYC : WAKE_STBY_CYC;
  localparam int unsigned CW = $clog2(MAX_CYC + 1);

  logic sleep_s, run_s;
  pm_mode_e mode_q, mode_d, req_mode;
  logic t_load, t_expired;
  logic [CW-1:0] t_len;
  logic ready_q, ref_q, amp_q, arr_q;

  pmc_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sleep_req, run_req}),
    .q   ({sleep_s, run_s})
  );

  always_comb begin
    if (sleep_s)     req_mode = PM_SHDN;
    else if (run_s)  req_mode = PM_ACTIVE;
    else             req_mode = PM_STBY;
  end

  always_comb begin
    mode_d = mode_q;
    t_load = 1'b0;
    t_len  = CW'(WAKE_STBY_CYC);
    unique case (mode_q)
      PM_ACTIVE: mode_d = req_mode;
      PM_STBY, PM_SHDN: begin
        if (req_mode == PM_ACTIVE) begin
          mode_d = PM_WAKE;
          t_load = 1'b1;
          t_len  = (mode_q == PM_SHDN) ? CW'(WAKE_SHDN_CYC) : CW'(WAKE_STBY_CYC);
        end else begin
          mode_d = req_mode;
        end
      end
      PM_WAKE: begin
        if (req_mode != PM_ACTIVE) mode_d = req_mode;
        else if (t_expired)        mode_d = PM_ACTIVE;
      end
      default: mode_d = PM_SHDN;
    endcase
  end

  pmc_wake_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_len),
    .expired  (t_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PM_SHDN;
      ready_q <= 1'b0;
      ref_q   <= 1'b0;
      amp_q   <= 1'b0;
      arr_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      ready_q <= (mode_d == PM_ACTIVE);
      ref_q   <= (mode_d != PM_SHDN);
      amp_q   <= (mode_d != PM_SHDN);
      arr_q   <= (mode_d == PM_ACTIVE) || (mode_d == PM_WAKE);
    end
  end

  pmc_hold #(.DW(DW), .PARK_ZERO(PARK_ZERO)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (mode_q == PM_ACTIVE),
    .park    (pm_is_low(mode_q)),
    .din     (data_in),
    .dout    (data_out),
    .dis     (out_dis)
  );

  assign mode   = mode_q;
  assign ready  = ready_q;
  assign ref_en = ref_q;
  assign amp_en = amp_q;
  assign arr_en = arr_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int unsigned DW            = 8,
  parameter int unsigned WAKE_SHDN_CYC = 2000,
  parameter int unsigned WAKE_STBY_CYC = 20,
  parameter bit          PARK_ZERO     = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep_s,
  input logic          run_s,
  input logic [1:0]    mode,
  input logic          ready,
  input logic          ref_en,
  input logic          amp_en,
  input logic          arr_en,
  input logic [DW-1:0] data_out,
  input logic          out_dis
);
  localparam logic [1:0] M_ACT = 2'b00, M_STBY = 2'b01, M_SHDN = 2'b10, M_WAKE = 2'b11;

  logic [31:0] wake_len_q;
  logic [1:0]  wake_src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_len_q <= '0;
      wake_src_q <= M_SHDN;
    end else if (mode == M_WAKE) begin
      wake_len_q <= wake_len_q + 32'd1;
    end else begin
      wake_len_q <= '0;
      wake_src_q <= mode;
    end
  end

  a_r2_enter_shdn: assert property (@(posedge clk) disable iff (rst)
    sleep_s |=> (mode == M_SHDN));
  a_r2_shdn_all_off: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SHDN) |-> (!ref_en && !amp_en && !arr_en));
  a_r3_enter_stby: assert property (@(posedge clk) disable iff (rst)
    (!sleep_s && !run_s) |=> (mode == M_STBY));
  a_r3_stby_enables: assert property (@(posedge clk) disable iff (rst)
    (mode == M_STBY) |-> (ref_en && amp_en && !arr_en));
  a_r6_wake_enables: assert property (@(posedge clk) disable iff (rst)
    (mode == M_WAKE) |-> (ref_en && amp_en && arr_en && !ready));
  a_r7_abort_wake: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_WAKE) && !run_s) |=> ((mode == M_STBY) || (mode == M_SHDN)));
  a_r12_ready_mode: assert property (@(posedge clk) disable iff (rst)
    ready == (mode == M_ACT));
  // R4 and R5: wake window length, measured by counter
  a_r4_r5_wake_len: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_ACT) && (wake_len_q != 0)) |->
      (wake_len_q == ((wake_src_q == M_SHDN) ? WAKE_SHDN_CYC : WAKE_STBY_CYC)));
  a_r4_ready_after_wake: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(mode) == M_WAKE));
  a_r9_r10_park: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_STBY) || (mode == M_SHDN)) |->
      (PARK_ZERO ? ((data_out == '0) && !out_dis) : out_dis));
endmodule

bind pwr_mode_ctrl pmc_checker #(
  .DW(DW), .WAKE_SHDN_CYC(WAKE_SHDN_CYC), .WAKE_STBY_CYC(WAKE_STBY_CYC), .PARK_ZERO(PARK_ZERO)
) u_pmc_chk (
  .clk(clk), .rst(rst), .sleep_s(sleep_s), .run_s(run_s), .mode(mode), .ready(ready),
  .ref_en(ref_en), .amp_en(amp_en), .arr_en(arr_en), .data_out(data_out), .out_dis(out_dis)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int DW = 8;
  localparam int NS = 40;
  localparam int NT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b1;
  logic run_req = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [1:0] mode, mode_z;
  logic ready, ref_en, amp_en, arr_en, out_dis;
  logic ready_z, ref_z, amp_z, arr_z, out_dis_z;
  logic [DW-1:0] data_out, data_out_z;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.DW(DW), .WAKE_SHDN_CYC(NS), .WAKE_STBY_CYC(NT), .PARK_ZERO(1'b1)) i_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .run_req(run_req), .data_in(data_in),
    .mode(mode), .ready(ready), .ref_en(ref_en), .amp_en(amp_en), .arr_en(arr_en),
    .data_out(data_out), .out_dis(out_dis));

  pwr_mode_ctrl #(.DW(DW), .WAKE_SHDN_CYC(NS), .WAKE_STBY_CYC(NT), .PARK_ZERO(1'b0)) i_pwr_mode_ctrl_dis (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .run_req(run_req), .data_in(data_in),
    .mode(mode_z), .ready(ready_z), .ref_en(ref_z), .amp_en(amp_z), .arr_en(arr_z),
    .data_out(data_out_z), .out_dis(out_dis_z));

  typedef struct packed {
    logic       sl;
    logic       rn;
    logic [7:0] wt;
    logic [1:0] md;
    logic [3:0] fl;   // {ref, amp, arr, ready}
    logic [7:0] tag;
  } vec_t;

  // mode codes: 00 active, 01 standby, 10 shutdown, 11 wake
  localparam vec_t VEC [19] = '{
    '{1'b0, 1'b0, 8'd2,  2'b10, 4'b0000, 8'd8},  // R8 not yet visible
    '{1'b0, 1'b0, 8'd1,  2'b01, 4'b1100, 8'd3},  // R3 standby
    '{1'b0, 1'b1, 8'd3,  2'b11, 4'b1110, 8'd6},  // R6 wake enables
    '{1'b0, 1'b1, 8'd5,  2'b11, 4'b1110, 8'd5},  // R5 still waking
    '{1'b0, 1'b1, 8'd1,  2'b00, 4'b1111, 8'd5},  // R5 active after NT
    '{1'b1, 1'b1, 8'd3,  2'b10, 4'b0000, 8'd2},  // R2 sleep overrides run
    '{1'b1, 1'b0, 8'd3,  2'b10, 4'b0000, 8'd2},  // R2
    '{1'b0, 1'b1, 8'd3,  2'b11, 4'b1110, 8'd4},  // R4 wake from shutdown
    '{1'b0, 1'b1, 8'd39, 2'b11, 4'b1110, 8'd4},  // R4 last wake cycle
    '{1'b0, 1'b1, 8'd1,  2'b00, 4'b1111, 8'd4},  // R4 active, R12
    '{1'b0, 1'b0, 8'd2,  2'b00, 4'b1111, 8'd8},  // R8 latency
    '{1'b0, 1'b0, 8'd1,  2'b01, 4'b1100, 8'd3},  // R3
    '{1'b0, 1'b1, 8'd5,  2'b11, 4'b1110, 8'd5},  // R5
    '{1'b1, 1'b1, 8'd2,  2'b11, 4'b1110, 8'd7},  // R7 before abort visible
    '{1'b1, 1'b1, 8'd1,  2'b10, 4'b0000, 8'd7},  // R7 abort to shutdown
    '{1'b0, 1'b1, 8'd10, 2'b11, 4'b1110, 8'd4},  // R4
    '{1'b0, 1'b0, 8'd3,  2'b01, 4'b1100, 8'd7},  // R7 abort to standby
    '{1'b1, 1'b0, 8'd3,  2'b10, 4'b0000, 8'd2},  // R2
    '{1'b0, 1'b0, 8'd3,  2'b01, 4'b1100, 8'd3}   // R3 shutdown to standby
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    wait_edges(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "mode", mode, 2'b10);
    chk("R1", "enables+ready", {ref_en, amp_en, arr_en, ready}, 4'b0000);
    chk("R1", "data_out", data_out, 0);

    for (int i = 0; i < 19; i++) begin
      sleep_req = VEC[i].sl;
      run_req   = VEC[i].rn;
      wait_edges(int'(VEC[i].wt));
      chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec %0d mode", i), mode, VEC[i].md);
      chk($sformatf("R%0d", VEC[i].tag), $sformatf("vec %0d flags", i),
          {ref_en, amp_en, arr_en, ready}, VEC[i].fl);
    end

    // R11: data capture in active, currently standby
    data_in = 8'hA5;
    run_req = 1'b1;
    wait_edges(NT + 3);
    chk("R12", "active ready", ready, 1'b1);
    chk("R11", "first active shows held", data_out, 8'h00);
    wait_edges(1);
    chk("R11", "capture A5", data_out, 8'hA5);
    data_in = 8'h5A;
    wait_edges(1);
    chk("R11", "capture 5A", data_out, 8'h5A);
    data_in = 8'hC3;
    run_req = 1'b0;
    wait_edges(3);
    chk("R3", "standby mode", mode, 2'b01);
    chk("R9", "park zero data", data_out, 8'h00);
    chk("R9", "park zero dis", out_dis, 1'b0);
    chk("R10", "disable flag", out_dis_z, 1'b1);
    chk("R10", "held data", data_out_z, 8'hC3);
    data_in = 8'h11;
    wait_edges(2);
    chk("R9", "ignores data_in in standby", data_out, 8'h00);
    chk("R10", "ignores data_in in standby", data_out_z, 8'hC3);
    run_req = 1'b1;
    wait_edges(3);
    chk("R11", "wake restores", data_out, 8'hC3);
    chk("R10", "dis cleared in wake", out_dis_z, 1'b0);
    wait_edges(NT);
    chk("R11", "first active held", data_out, 8'hC3);
    wait_edges(1);
    chk("R11", "new capture", data_out, 8'h11);

    // R2 in shutdown, PARK_ZERO=0 keeps code
    sleep_req = 1'b1;
    wait_edges(3);
    chk("R2", "shutdown mode", mode, 2'b10);
    chk("R10", "shutdown dis", out_dis_z, 1'b1);
    chk("R9", "shutdown zero", data_out, 8'h00);

    // R1 reset while active
    sleep_req = 1'b0;
    wait_edges(NS + 4);
    chk("R4", "active before reset", mode, 2'b00);
    rst = 1'b1;
    wait_edges(1);
    rst = 1'b0;
    chk("R1", "mode after reset", mode, 2'b10);
    chk("R1", "flags after reset", {ref_en, amp_en, arr_en, ready}, 4'b0000);
    chk("R1", "data after reset", data_out_z, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule